// File: doc/BRIEF.md
# Triggered Circular Trace Capture Buffer

This block records a stream of trace words (an address and a data value each) into an on-chip ring. Once armed, it can keep overwriting the oldest entries so that the history just before an interesting moment is always present. The capture can instead begin at that moment and fill the ring from there. The interesting moment is a trigger built from up to four sources: an inclusive address window, a masked data compare, the Nth marked event, and an external line. The enabled sources are combined either by OR or by AND. After the trigger, a programmable number of further words is kept before the ring freezes.

Once the ring is frozen, a host pulls the words out one per request in the order they arrived, oldest first. A streaming mode sends every accepted word to a separate output port one cycle later instead of storing it. This suits captures longer than the ring. Status outputs show whether capture is armed, whether a trigger was seen, whether capture has ended, and how many words are held.

Top module: `trace_capture`

## Requirements
- R1: After reset the block is idle: sts_armed, sts_triggered, sts_done, rd_valid and st_valid are 0 and sts_count is 0, and a read request returns nothing.
- R2: A start pulse clears the ring, the trigger flag and the event counter and arms capture. In stop-action ring mode every valid word is stored, the oldest is overwritten once DEPTH words are held, and sts_count = min(words stored, DEPTH).
- R3: In stop action the word that fires the trigger is stored and sets sts_triggered. Then P more valid words are stored and capture ends (sts_done=1, sts_armed=0). P is cfg_post clamped to DEPTH-1, and P=0 ends capture on the trigger word itself.
- R4: When done, each rd_en pulse yields rd_valid one cycle later with the next word in arrival order. Reading starts at the oldest entry: the write position if the ring has wrapped, otherwise entry 0. Requests beyond sts_count return nothing.
- R5: While sts_armed is 1, rd_en has no effect and rd_valid stays 0.
- R6: Source bit 0 of cfg_src_en fires when cfg_addr_lo <= tr_addr <= cfg_addr_hi (both bounds inclusive).
- R7: Source bit 1 fires when (tr_data XOR cfg_data_val) AND cfg_data_mask is zero.
- R8: Source bit 2 fires on the word carrying the cfg_evt_n-th tr_evt since the start pulse. cfg_evt_n = 0 never fires.
- R9: Source bit 3 fires on a valid word presented while ext_trig is 1.
- R10: With cfg_all = 0 the trigger is the OR of the enabled sources. With cfg_all = 1 all enabled sources must hit on the same word. With no source enabled it never fires.
- R11: With cfg_action = 1 (start action) nothing is stored before the trigger. The trigger word and the next DEPTH-1 words are stored, and then capture ends.
- R12: With cfg_stream = 1 accepted words appear on st_valid/st_addr/st_data one cycle after acceptance and nothing is stored. With start action, streaming continues after the trigger until a stop pulse.
- R13: A stop pulse while armed ends capture at once (sts_done=1), keeping what was stored.
- R14: Once done, further trace words do not change sts_count or the stored contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse: clear and arm capture |
| stop | input | 1 | Pulse: end capture now |
| cfg_action | input | 1 | 0 = trigger ends capture, 1 = trigger begins capture |
| cfg_stream | input | 1 | 1 = forward words to stream port instead of storing |
| cfg_post | input | $clog2(DEPTH)+1 | Words kept after the trigger (stop action) |
| cfg_src_en | input | 4 | Source enables: bit0 address, bit1 data, bit2 event, bit3 external |
| cfg_all | input | 1 | 0 = OR of enabled sources, 1 = AND |
| cfg_addr_lo | input | ADDR_W | Address window lower bound |
| cfg_addr_hi | input | ADDR_W | Address window upper bound |
| cfg_data_val | input | DATA_W | Data compare value |
| cfg_data_mask | input | DATA_W | Data compare bit mask |
| cfg_evt_n | input | EVT_W | Event ordinal that fires |
| tr_valid | input | 1 | Trace word present |
| tr_addr | input | ADDR_W | Trace word address |
| tr_data | input | DATA_W | Trace word data |
| tr_evt | input | 1 | Trace word carries an event mark |
| ext_trig | input | 1 | External trigger line |
| rd_en | input | 1 | Readout request |
| rd_valid | output | 1 | Readout word present |
| rd_addr | output | ADDR_W | Readout address |
| rd_data | output | DATA_W | Readout data |
| st_valid | output | 1 | Stream word present |
| st_addr | output | ADDR_W | Stream address |
| st_data | output | DATA_W | Stream data |
| sts_armed | output | 1 | Capture in progress |
| sts_triggered | output | 1 | Trigger seen since start |
| sts_done | output | 1 | Capture ended |
| sts_count | output | $clog2(DEPTH)+1 | Stored word count |

## Verification
The bench sweeps the trigger position across and beyond one ring length, and the post-trigger depth over zero, one, mid, DEPTH-1 and an over-range value. Every position of the ring seam is therefore read back. A design that rotated readout from the wrong entry after a wrap, or that was off by one in the countdown, would return a shifted or truncated sequence. A design that failed to clamp would lose the trigger word. Further runs cover the Nth-event ordinal, a masked data compare, AND against OR combination and a combination with nothing enabled. They also cover start action, both streaming variants, a manual stop and reads attempted while armed or past the stored count. A design with a wrong combine rule, a wrong event ordinal or a leaky read gate shows a wrong trigger point, a wrong count or a spurious rd_valid.

// File: rtl/trc_pkg.sv
package trc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_POST  = 2'd2,
        ST_DONE  = 2'd3
    } cap_state_e;

    typedef enum logic {
        ACT_STOP  = 1'b0,
        ACT_START = 1'b1
    } trig_act_e;

    localparam int NSRC = 4;

    typedef struct packed {
        logic ext;
        logic evt;
        logic data;
        logic addr;
    } trig_hits_t;

    function automatic logic combine_hits(input trig_hits_t hits,
                                          input logic [NSRC-1:0] en,
                                          input logic all_mode);
        logic [NSRC-1:0] sel;
        sel = hits & en;
        if (en == '0)
            return 1'b0;
        if (all_mode)
            return sel == en;
        return |sel;
    endfunction

endpackage

// File: rtl/trc_trigger.sv
module trc_trigger
    import trc_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int EVT_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              active,
    input  logic              tr_valid,
    input  logic [ADDR_W-1:0] tr_addr,
    input  logic [DATA_W-1:0] tr_data,
    input  logic              tr_evt,
    input  logic              ext_trig,
    input  logic [ADDR_W-1:0] cfg_addr_lo,
    input  logic [ADDR_W-1:0] cfg_addr_hi,
    input  logic [DATA_W-1:0] cfg_data_val,
    input  logic [DATA_W-1:0] cfg_data_mask,
    input  logic [EVT_W-1:0]  cfg_evt_n,
    input  logic [NSRC-1:0]   cfg_src_en,
    input  logic              cfg_all,
    output logic              fire
);

    logic [EVT_W-1:0] evt_cnt;
    trig_hits_t       hits;

    always_comb begin
        hits.addr = (tr_addr >= cfg_addr_lo) && (tr_addr <= cfg_addr_hi);
        hits.data = ((tr_data ^ cfg_data_val) & cfg_data_mask) == '0;
        hits.evt  = tr_evt && (cfg_evt_n != '0) &&
                    ((evt_cnt + EVT_W'(1)) == cfg_evt_n);
        hits.ext  = ext_trig;
        fire      = active && tr_valid && combine_hits(hits, cfg_src_en, cfg_all);
    end

    // event ordinal counter, saturating
    always_ff @(posedge clk) begin
        if (rst || clr)
            evt_cnt <= '0;
        else if (active && tr_valid && tr_evt && (evt_cnt != '1))
            evt_cnt <= evt_cnt + EVT_W'(1);
    end

endmodule

// File: rtl/trc_ctrl.sv
module trc_ctrl
    import trc_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          stop,
    input  logic          tr_valid,
    input  logic          fire,
    input  logic          cfg_action,
    input  logic          cfg_stream,
    input  logic [CW-1:0] cfg_post,
    output cap_state_e    state,
    output logic          wr_en,
    output logic          triggered
);

    localparam logic [CW-1:0] MAX_POST = CW'(DEPTH - 1);

    trig_act_e     act;
    logic [CW-1:0] eff_post;
    logic [CW-1:0] remain;
    logic          endless;

    always_comb begin
        act = trig_act_e'(cfg_action);
        if (act == ACT_START)
            eff_post = MAX_POST;
        else if (cfg_post > MAX_POST)
            eff_post = MAX_POST;
        else
            eff_post = cfg_post;
        endless = cfg_stream && (act == ACT_START);
        wr_en = tr_valid && !start && !stop &&
                (((state == ST_ARMED) && ((act == ACT_STOP) || fire)) ||
                 (state == ST_POST));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            remain    <= '0;
            triggered <= 1'b0;
        end else if (start) begin
            state     <= ST_ARMED;
            remain    <= '0;
            triggered <= 1'b0;
        end else if (stop && ((state == ST_ARMED) || (state == ST_POST))) begin
            state <= ST_DONE;
        end else begin
            case (state)
                ST_ARMED: begin
                    if (tr_valid && fire) begin
                        triggered <= 1'b1;
                        if ((eff_post == '0) && !endless) begin
                            state <= ST_DONE;
                        end else begin
                            remain <= eff_post;
                            state  <= ST_POST;
                        end
                    end
                end
                ST_POST: begin
                    if (tr_valid && !endless) begin
                        if (remain <= CW'(1))
                            state <= ST_DONE;
                        remain <= remain - CW'(1);
                    end
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/trc_store.sv
module trc_store #(
    parameter int DEPTH = 16,
    parameter int WW    = 32,
    parameter int IW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          wr_en,
    input  logic          stream,
    input  logic [WW-1:0] wr_word,
    input  logic          rd_allow,
    input  logic          rd_en,
    output logic          st_valid,
    output logic [WW-1:0] st_word,
    output logic          rd_valid,
    output logic [WW-1:0] rd_word,
    output logic [CW-1:0] count
);

    logic [WW-1:0] mem [DEPTH];
    logic [IW-1:0] wptr;
    logic          wrapped;
    logic [CW-1:0] rd_cnt;
    logic [IW-1:0] oldest;
    logic [IW-1:0] rd_idx;
    logic          store;
    logic          take;

    always_comb begin
        store  = wr_en && !stream;
        count  = wrapped ? CW'(DEPTH) : {1'b0, wptr};
        oldest = wrapped ? wptr : '0;
        rd_idx = oldest + rd_cnt[IW-1:0];
        take   = rd_allow && rd_en && (rd_cnt < count);
    end

    always_ff @(posedge clk) begin
        if (store)
            mem[wptr] <= wr_word;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            wptr    <= '0;
            wrapped <= 1'b0;
            rd_cnt  <= '0;
        end else begin
            if (store) begin
                wptr <= wptr + IW'(1);
                if (wptr == IW'(DEPTH - 1))
                    wrapped <= 1'b1;
            end
            if (take)
                rd_cnt <= rd_cnt + CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            rd_valid <= 1'b0;
            rd_word  <= '0;
            st_valid <= 1'b0;
            st_word  <= '0;
        end else begin
            rd_valid <= take;
            if (take)
                rd_word <= mem[rd_idx];
            st_valid <= wr_en && stream;
            if (wr_en && stream)
                st_word <= wr_word;
        end
    end

endmodule

// File: rtl/trace_capture.sv
module trace_capture
    import trc_pkg::*;
#(
    parameter int DEPTH  = 16,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int EVT_W  = 8,
    parameter int CW     = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              stop,
    input  logic              cfg_action,
    input  logic              cfg_stream,
    input  logic [CW-1:0]     cfg_post,
    input  logic [3:0]        cfg_src_en,
    input  logic              cfg_all,
    input  logic [ADDR_W-1:0] cfg_addr_lo,
    input  logic [ADDR_W-1:0] cfg_addr_hi,
    input  logic [DATA_W-1:0] cfg_data_val,
    input  logic [DATA_W-1:0] cfg_data_mask,
    input  logic [EVT_W-1:0]  cfg_evt_n,
    input  logic              tr_valid,
    input  logic [ADDR_W-1:0] tr_addr,
    input  logic [DATA_W-1:0] tr_data,
    input  logic              tr_evt,
    input  logic              ext_trig,
    input  logic              rd_en,
    output logic              rd_valid,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              st_valid,
    output logic [ADDR_W-1:0] st_addr,
    output logic [DATA_W-1:0] st_data,
    output logic              sts_armed,
    output logic              sts_triggered,
    output logic              sts_done,
    output logic [CW-1:0]     sts_count
);

    localparam int WW = ADDR_W + DATA_W;
    localparam int IW = $clog2(DEPTH);

    cap_state_e    state;
    logic          fire;
    logic          wr_en;
    logic          armed_now;
    logic [WW-1:0] rd_word;
    logic [WW-1:0] st_word;

    assign armed_now = (state == ST_ARMED);

    trc_trigger #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .EVT_W  (EVT_W)
    ) u_trig (
        .clk           (clk),
        .rst           (rst),
        .clr           (start),
        .active        (armed_now),
        .tr_valid      (tr_valid),
        .tr_addr       (tr_addr),
        .tr_data       (tr_data),
        .tr_evt        (tr_evt),
        .ext_trig      (ext_trig),
        .cfg_addr_lo   (cfg_addr_lo),
        .cfg_addr_hi   (cfg_addr_hi),
        .cfg_data_val  (cfg_data_val),
        .cfg_data_mask (cfg_data_mask),
        .cfg_evt_n     (cfg_evt_n),
        .cfg_src_en    (cfg_src_en),
        .cfg_all       (cfg_all),
        .fire          (fire)
    );

    trc_ctrl #(
        .DEPTH (DEPTH),
        .CW    (CW)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .stop       (stop),
        .tr_valid   (tr_valid),
        .fire       (fire),
        .cfg_action (cfg_action),
        .cfg_stream (cfg_stream),
        .cfg_post   (cfg_post),
        .state      (state),
        .wr_en      (wr_en),
        .triggered  (sts_triggered)
    );

    trc_store #(
        .DEPTH (DEPTH),
        .WW    (WW),
        .IW    (IW),
        .CW    (CW)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .clr      (start),
        .wr_en    (wr_en),
        .stream   (cfg_stream),
        .wr_word  ({tr_addr, tr_data}),
        .rd_allow (state == ST_DONE),
        .rd_en    (rd_en),
        .st_valid (st_valid),
        .st_word  (st_word),
        .rd_valid (rd_valid),
        .rd_word  (rd_word),
        .count    (sts_count)
    );

    assign rd_addr   = rd_word[WW-1:DATA_W];
    assign rd_data   = rd_word[DATA_W-1:0];
    assign st_addr   = st_word[WW-1:DATA_W];
    assign st_data   = st_word[DATA_W-1:0];
    assign sts_armed = (state == ST_ARMED) || (state == ST_POST);
    assign sts_done  = (state == ST_DONE);

endmodule

// File: rtl/trace_capture_chk.sv
module trace_capture_chk #(
    parameter int DEPTH = 16,
    parameter int CW    = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          stop,
    input logic          cfg_stream,
    input logic          rd_valid,
    input logic          st_valid,
    input logic          sts_armed,
    input logic          sts_triggered,
    input logic          sts_done,
    input logic [CW-1:0] sts_count
);

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!sts_armed && !sts_done && !sts_triggered && sts_count == '0));

    a_r2_start_arms: assert property (@(posedge clk) disable iff (rst)
        start |=> (sts_armed && !sts_triggered && sts_count == '0));

    a_r2_count_bounded: assert property (@(posedge clk) disable iff (rst)
        sts_count <= CW'(DEPTH));

    a_r5_no_read_armed: assert property (@(posedge clk) disable iff (rst)
        sts_armed |=> !rd_valid);

    a_r12_no_stream_out: assert property (@(posedge clk) disable iff (rst)
        !cfg_stream |=> !st_valid);

    a_r13_stop_ends: assert property (@(posedge clk) disable iff (rst)
        (stop && !start && sts_armed) |=> sts_done);

    a_r14_done_frozen: assert property (@(posedge clk) disable iff (rst)
        (sts_done && !start) |=> (sts_done && $stable(sts_count)));

endmodule

bind trace_capture trace_capture_chk #(
    .DEPTH (DEPTH),
    .CW    (CW)
) u_chk (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .stop          (stop),
    .cfg_stream    (cfg_stream),
    .rd_valid      (rd_valid),
    .st_valid      (st_valid),
    .sts_armed     (sts_armed),
    .sts_triggered (sts_triggered),
    .sts_done      (sts_done),
    .sts_count     (sts_count)
);

// File: tb/trace_capture_test.sv
`timescale 1ns/1ps
module trace_capture_test;

    localparam int D  = 8;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int EW = 4;
    localparam int CW = $clog2(D) + 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0, stop = 1'b0;
    logic          cfg_action = 1'b0, cfg_stream = 1'b0, cfg_all = 1'b0;
    logic [CW-1:0] cfg_post = '0;
    logic [3:0]    cfg_src_en = '0;
    logic [AW-1:0] cfg_addr_lo = '0, cfg_addr_hi = '0;
    logic [DW-1:0] cfg_data_val = '0, cfg_data_mask = '0;
    logic [EW-1:0] cfg_evt_n = '0;
    logic          tr_valid = 1'b0, tr_evt = 1'b0, ext_trig = 1'b0;
    logic [AW-1:0] tr_addr = '0;
    logic [DW-1:0] tr_data = '0;
    logic          rd_en = 1'b0;
    logic          rd_valid, st_valid;
    logic [AW-1:0] rd_addr, st_addr;
    logic [DW-1:0] rd_data, st_data;
    logic          sts_armed, sts_triggered, sts_done;
    logic [CW-1:0] sts_count;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;
    int st_n = 0;
    int st_a [0:63];
    int st_d [0:63];

    always #5 clk = ~clk;

    trace_capture #(.DEPTH(D), .ADDR_W(AW), .DATA_W(DW), .EVT_W(EW)) uut (
        .clk(clk), .rst(rst), .start(start), .stop(stop),
        .cfg_action(cfg_action), .cfg_stream(cfg_stream), .cfg_post(cfg_post),
        .cfg_src_en(cfg_src_en), .cfg_all(cfg_all),
        .cfg_addr_lo(cfg_addr_lo), .cfg_addr_hi(cfg_addr_hi),
        .cfg_data_val(cfg_data_val), .cfg_data_mask(cfg_data_mask),
        .cfg_evt_n(cfg_evt_n), .tr_valid(tr_valid), .tr_addr(tr_addr),
        .tr_data(tr_data), .tr_evt(tr_evt), .ext_trig(ext_trig),
        .rd_en(rd_en), .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_data(rd_data),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data),
        .sts_armed(sts_armed), .sts_triggered(sts_triggered),
        .sts_done(sts_done), .sts_count(sts_count)
    );

    function automatic int dval(int i);
        return (i * 3 + 1) & 16'hFFFF;
    endfunction

    always @(negedge clk) begin
        if (st_valid) begin
            if (st_n < 64) begin
                st_a[st_n] = int'(st_addr);
                st_d[st_n] = int'(st_data);
            end
            st_n = st_n + 1;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic cfg_clear();
        cfg_action = 1'b0; cfg_stream = 1'b0; cfg_all = 1'b0; cfg_post = '0;
        cfg_src_en = '0; cfg_addr_lo = '0; cfg_addr_hi = '0;
        cfg_data_val = '0; cfg_data_mask = '0; cfg_evt_n = '0;
    endtask

    task automatic arm();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        st_n = 0;
    endtask

    task automatic pulse_stop();
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
    endtask

    // words: addr = i, data = 3i+1, event mark when i%3==0, ext at ext_at
    task automatic feed(int n, int ext_at);
        for (int i = 0; i < n; i++) begin
            tr_valid = 1'b1;
            tr_addr  = AW'(i);
            tr_data  = DW'(dval(i));
            tr_evt   = (i % 3) == 0;
            ext_trig = (i == ext_at);
            @(negedge clk);
        end
        tr_valid = 1'b0; tr_evt = 1'b0; ext_trig = 1'b0;
    endtask

    task automatic drain(string req, int first, int n);
        for (int k = 0; k < n; k++) begin
            rd_en = 1'b1;
            @(negedge clk);
            rd_en = 1'b0;
            chk(req, "rd_valid", int'(rd_valid), 1);
            chk(req, "rd_addr", int'(rd_addr), first + k);
            chk(req, "rd_data", int'(rd_data), dval(first + k));
        end
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R4", "no word past count", int'(rd_valid), 0);
    endtask

    task automatic expect_done(string req, int trig, int cnt);
        chk(req, "done", int'(sts_done), 1);
        chk(req, "armed", int'(sts_armed), 0);
        chk(req, "triggered", int'(sts_triggered), trig);
        chk(req, "count (R14 words after done ignored)", int'(sts_count), cnt);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1", "armed", int'(sts_armed), 0);
        chk("R1", "done", int'(sts_done), 0);
        chk("R1", "triggered", int'(sts_triggered), 0);
        chk("R1", "count", int'(sts_count), 0);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        chk("R1", "rd_valid", int'(rd_valid), 0);
        chk("R1", "st_valid", int'(st_valid), 0);

        // R2 R3 R4 R6: sweep trigger position and post depth
        for (int t = 0; t < 11; t++) begin
            for (int pi = 0; pi < 5; pi++) begin
                int p, pe, last, cnt;
                p  = (pi == 0) ? 0 : (pi == 1) ? 1 : (pi == 2) ? 3 : (pi == 3) ? 7 : 9;
                pe = (p > D - 1) ? D - 1 : p;
                last = t + pe;
                cnt  = (last + 1 < D) ? last + 1 : D;
                cfg_clear();
                cfg_src_en = 4'b0001;
                cfg_addr_lo = AW'(t); cfg_addr_hi = AW'(t);
                cfg_post = CW'(p);
                arm();
                chk("R2", "armed after start", int'(sts_armed), 1);
                feed(last + 4, -1);
                expect_done("R3", 1, cnt);
                drain("R4", last + 1 - cnt, cnt);
            end
        end

        // R6 inclusive window lower bound
        cfg_clear(); cfg_src_en = 4'b0001;
        cfg_addr_lo = 16'd3; cfg_addr_hi = 16'd5; cfg_post = CW'(2);
        arm(); feed(12, -1);
        expect_done("R6", 1, 6);
        drain("R6", 0, 6);

        // R7 masked data compare: (3i+1)&3==0 first at i=1
        cfg_clear(); cfg_src_en = 4'b0010;
        cfg_data_val = 16'h0000; cfg_data_mask = 16'h0003; cfg_post = CW'(1);
        arm(); feed(10, -1);
        expect_done("R7", 1, 3);
        drain("R7", 0, 3);
        // R7 full mask, value of word 5
        cfg_clear(); cfg_src_en = 4'b0010;
        cfg_data_val = DW'(dval(5)); cfg_data_mask = 16'hFFFF;
        arm(); feed(10, -1);
        expect_done("R7", 1, 6);
        drain("R7", 0, 6);

        // R8 third event (events at 0,3,6) fires at word 6, post 2
        cfg_clear(); cfg_src_en = 4'b0100; cfg_evt_n = EW'(3); cfg_post = CW'(2);
        arm(); feed(14, -1);
        expect_done("R8", 1, 8);
        drain("R8", 1, 8);

        // R8 ordinal zero never fires; R5 read blocked; R13 stop
        cfg_clear(); cfg_src_en = 4'b0100; cfg_evt_n = '0;
        arm(); feed(20, -1);
        chk("R8", "no trigger", int'(sts_triggered), 0);
        chk("R8", "still armed", int'(sts_armed), 1);
        chk("R2", "ring full count", int'(sts_count), D);
        rd_en = 1'b1; @(negedge clk);
        chk("R5", "rd_valid while armed", int'(rd_valid), 0);
        @(negedge clk); rd_en = 1'b0;
        chk("R5", "rd_valid while armed", int'(rd_valid), 0);
        pulse_stop();
        expect_done("R13", 0, 8);
        drain("R2", 12, 8);

        // R13 stop before ring fills
        cfg_clear(); cfg_src_en = 4'b0001; cfg_addr_lo = 16'd50; cfg_addr_hi = 16'd50;
        arm(); feed(5, -1); pulse_stop(); feed(6, -1);
        expect_done("R13", 0, 5);
        drain("R13", 0, 5);

        // R9 external trigger at word 4, post 2
        cfg_clear(); cfg_src_en = 4'b1000; cfg_post = CW'(2);
        arm(); feed(12, 4);
        expect_done("R9", 1, 7);
        drain("R9", 0, 7);

        // R10 OR: address 9 or external at 4 -> 4
        cfg_clear(); cfg_src_en = 4'b1001; cfg_addr_lo = 16'd9; cfg_addr_hi = 16'd9;
        arm(); feed(12, 4);
        expect_done("R10", 1, 5);
        drain("R10", 0, 5);
        // R10 AND: address >=5 and even data -> word 5
        cfg_clear(); cfg_src_en = 4'b0011; cfg_all = 1'b1;
        cfg_addr_lo = 16'd5; cfg_addr_hi = 16'd30; cfg_data_mask = 16'h0001;
        arm(); feed(12, -1);
        expect_done("R10", 1, 6);
        drain("R10", 0, 6);
        // R10 AND with non-coincident sources never fires (ext at 4, addr 9)
        cfg_clear(); cfg_src_en = 4'b1001; cfg_all = 1'b1;
        cfg_addr_lo = 16'd9; cfg_addr_hi = 16'd9;
        arm(); feed(12, 4);
        chk("R10", "AND no coincidence", int'(sts_triggered), 0);
        pulse_stop();
        // R10 nothing enabled
        cfg_clear(); cfg_all = 1'b0;
        arm(); feed(12, 4);
        chk("R10", "no source enabled", int'(sts_triggered), 0);
        pulse_stop();

        // R11 start action: trigger at 3, stores 3..10
        cfg_clear(); cfg_action = 1'b1; cfg_src_en = 4'b0001;
        cfg_addr_lo = 16'd3; cfg_addr_hi = 16'd3;
        arm(); feed(3, -1);
        chk("R11", "nothing before trigger", int'(sts_count), 0);
        feed(20, -1);
        expect_done("R11", 1, 8);
        drain("R11", 3, 8);

        // R12 stream, stop action, trigger 2 post 2 -> words 0..4
        cfg_clear(); cfg_stream = 1'b1; cfg_src_en = 4'b0001;
        cfg_addr_lo = 16'd2; cfg_addr_hi = 16'd2; cfg_post = CW'(2);
        arm(); feed(9, -1); @(negedge clk);
        expect_done("R12", 1, 0);
        chk("R12", "stream words", st_n, 5);
        for (int k = 0; k < 5; k++) begin
            chk("R12", "stream addr", st_a[k], k);
            chk("R12", "stream data", st_d[k], dval(k));
        end
        // R12 stream, start action: runs from word 2 until stop
        cfg_clear(); cfg_stream = 1'b1; cfg_action = 1'b1; cfg_src_en = 4'b0001;
        cfg_addr_lo = 16'd2; cfg_addr_hi = 16'd2;
        arm(); feed(20, -1); @(negedge clk);
        chk("R12", "still streaming", int'(sts_armed), 1);
        chk("R12", "stream words", st_n, 18);
        for (int k = 0; k < 18; k++)
            chk("R12", "stream addr", st_a[k], k + 2);
        pulse_stop();
        expect_done("R12", 1, 0);

        if (!finished) begin
            finished = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule